// File: doc/BRIEF.md
# Exception capture and vectoring unit

This unit sits beside the control sequencer of a multicycle processor and handles the two faults that the core can raise. The first is an opcode that no decode path accepts. The second is an arithmetic overflow reported by the ALU while an R-type result is being written back. When either fault is seen, the unit takes over for three cycles. In the first cycle it records which fault occurred. In the second it stores the address of the faulting instruction, which is the already-incremented program counter minus four. In the third it issues a one-cycle program counter load with the handler address, after which the normal fetch resumes.

The fault code lives in bit 0 of a cause register, whose other bits stay zero. A parameter chooses how the handler is found. In single-handler mode every fault goes to one address, and software reads the cause register to tell the faults apart. In vectored mode the overflow handler sits a fixed stride above the illegal-opcode handler.

The instruction that overflows has already written its destination register by the time the fault is taken. The unit does not undo that write.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset, `epc` and `cause` are zero and `exc_busy` and `pc_we` are low.
- R2: With `decode_en` high while idle, the sequence starts if and only if `opcode` is not one of the six accepted codes: 6'b100011, 6'b101011, 6'b000000, 6'b001011, 6'b000100 and 6'b000010.
- R3: With `rtype_wr` and `alu_ovf` both high while idle, the overflow sequence starts. Either signal alone starts nothing. If an illegal opcode at decode and an overflow are presented together, the illegal-opcode fault wins.
- R4: The edge after entry writes `cause` with bit 0 set to 1 for overflow or 0 for an illegal opcode, and all other bits set to zero.
- R5: The second edge after entry writes `epc` with `pc_in` minus 4, modulo 2^XLEN.
- R6: In the cycle after `epc` is written, `pc_we` is high for exactly one cycle. In single-handler mode `pc_next` equals HANDLER_ADDR in that cycle. After that cycle the unit is idle again.
- R7: When VECTORED=1, `pc_next` in the load cycle is HANDLER_ADDR for an illegal opcode and HANDLER_ADDR + VEC_STRIDE for overflow.
- R8: While `exc_busy` is high, new fault triggers are ignored. They do not restart the sequence, stretch it, or change `cause`.
- R9: `epc` and `cause` keep their values whenever they are not being written, even when `pc_in` changes.
- R10: `exc_busy` is high from the edge that accepts a fault through the load cycle, which gives three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| decode_en | input | 1 | Controller is in its decode state |
| opcode | input | 6 | Opcode field of the instruction register |
| rtype_wr | input | 1 | Controller is in its R-type write-back state |
| alu_ovf | input | 1 | ALU signed overflow flag |
| pc_in | input | XLEN | Current program counter (already incremented by 4) |
| exc_busy | output | 1 | Exception sequence in progress |
| pc_we | output | 1 | Program counter load strobe |
| pc_next | output | XLEN | Handler address to load into the program counter |
| epc | output | XLEN | Saved faulting instruction address |
| cause | output | XLEN | Cause register; bit 0 is 1 for overflow and 0 for an illegal opcode |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the default single-handler setting and the other uses VECTORED=1, so each handler load is checked under both address rules in the same cycle. The opcode is only 6 bits wide, so all 64 codes can be swept at decode. This covers every illegal code and proves that the six accepted ones start nothing. The saved-address arithmetic is driven with program counter values that include 0 and 4, which brings the wrap below zero and the zero result within reach.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int OP_W = 6;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ILL  = 3'd1,
    S_OVF  = 3'd2,
    S_DEC  = 3'd3,
    S_VEC  = 3'd4
  } exc_state_t;

  // Opcodes the decoder has a path for.
  function automatic logic op_known(input logic [OP_W-1:0] op);
    case (op)
      6'b100011, 6'b101011, 6'b000000,
      6'b001011, 6'b000100, 6'b000010: op_known = 1'b1;
      default:                         op_known = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/exc_detect.sv
module exc_detect
  import exc_pkg::*;
(
  input  logic            idle,
  input  logic            decode_en,
  input  logic [OP_W-1:0] opcode,
  input  logic            rtype_wr,
  input  logic            alu_ovf,
  output logic            ill_hit,
  output logic            ovf_hit,
  output logic            take,
  output logic            take_ovf
);
  always_comb begin
    ill_hit  = decode_en && !op_known(opcode);
    ovf_hit  = rtype_wr && alu_ovf;
    take     = idle && (ill_hit || ovf_hit);
    // an illegal opcode outranks an overflow presented at the same time
    take_ovf = !ill_hit;
  end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_ovf,
  output logic idle,
  output logic busy,
  output logic cause_we,
  output logic cause_sel,
  output logic epc_we,
  output logic pc_we
);
  exc_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:       if (take) st_d = take_ovf ? S_OVF : S_ILL;
      S_ILL, S_OVF: st_d = S_DEC;
      S_DEC:        st_d = S_VEC;
      S_VEC:        st_d = S_IDLE;
      default:      st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    idle      = (st_q == S_IDLE);
    busy      = !idle;
    cause_we  = (st_q == S_ILL) || (st_q == S_OVF);
    cause_sel = (st_q == S_OVF);
    epc_we    = (st_q == S_DEC);
    pc_we     = (st_q == S_VEC);
  end
endmodule

// File: rtl/exc_regs.sv
module exc_regs #(
  parameter int XLEN = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cause_we,
  input  logic            cause_sel,
  input  logic            epc_we,
  input  logic [XLEN-1:0] pc_in,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] cause
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  // undo the fetch increment to point at the faulting instruction
  function automatic logic [XLEN-1:0] back_one(input logic [XLEN-1:0] pc);
    back_one = pc - STEP;
  endfunction

  function automatic logic [XLEN-1:0] cause_word(input logic sel);
    cause_word = {{(XLEN-1){1'b0}}, sel};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= '0;
    end else begin
      if (cause_we) cause <= cause_word(cause_sel);
      if (epc_we)   epc   <= back_one(pc_in);
    end
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h4000_0000,
  parameter logic [XLEN-1:0] VEC_STRIDE   = 32'h0000_0040,
  parameter bit              VECTORED     = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            decode_en,
  input  logic [5:0]      opcode,
  input  logic            rtype_wr,
  input  logic            alu_ovf,
  input  logic [XLEN-1:0] pc_in,
  output logic            exc_busy,
  output logic            pc_we,
  output logic [XLEN-1:0] pc_next,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] cause
);
  logic idle, ill_hit, ovf_hit, take, take_ovf;
  logic cause_we, cause_sel, epc_we;

  exc_detect u_detect (
    .idle(idle), .decode_en(decode_en), .opcode(opcode),
    .rtype_wr(rtype_wr), .alu_ovf(alu_ovf),
    .ill_hit(ill_hit), .ovf_hit(ovf_hit), .take(take), .take_ovf(take_ovf)
  );

  exc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .take_ovf(take_ovf),
    .idle(idle), .busy(exc_busy), .cause_we(cause_we),
    .cause_sel(cause_sel), .epc_we(epc_we), .pc_we(pc_we)
  );

  exc_regs #(.XLEN(XLEN)) u_regs (
    .clk(clk), .rst_n(rst_n), .cause_we(cause_we), .cause_sel(cause_sel),
    .epc_we(epc_we), .pc_in(pc_in), .epc(epc), .cause(cause)
  );

  // cause is already written when the load cycle arrives
  generate
    if (VECTORED) begin : g_vec
      assign pc_next = cause[0] ? (HANDLER_ADDR + VEC_STRIDE) : HANDLER_ADDR;
    end else begin : g_single
      assign pc_next = HANDLER_ADDR;
    end
  endgenerate
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_busy,
  input logic            pc_we,
  input logic            cause_we,
  input logic            cause_sel,
  input logic            epc_we,
  input logic [XLEN-1:0] pc_in,
  input logic [XLEN-1:0] epc,
  input logic [XLEN-1:0] cause
);
  p_cause_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we |=> cause == {{(XLEN-1){1'b0}}, $past(cause_sel)});
  p_epc_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    epc_we |=> epc == ($past(pc_in) - XLEN'(4)));
  p_cause_to_epc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we |=> epc_we && exc_busy);
  p_epc_to_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    epc_we |=> pc_we);
  p_load_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> !pc_we && !exc_busy);
  p_cause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_we |=> $stable(cause));
  p_epc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !epc_we |=> $stable(epc));
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_busy && !pc_we) |=> exc_busy && !cause_we || epc_we || pc_we);
endmodule

bind exc_vector_unit exc_vector_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_busy(exc_busy), .pc_we(pc_we),
  .cause_we(cause_we), .cause_sel(cause_sel), .epc_we(epc_we),
  .pc_in(pc_in), .epc(epc), .cause(cause)
);

// File: tb/exc_vector_unit_tb.sv
module exc_vector_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] HBASE = 32'h4000_0000;
  localparam logic [31:0] HSTEP = 32'h0000_0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic decode_en = 1'b0, rtype_wr = 1'b0, alu_ovf = 1'b0;
  logic [5:0] opcode = '0;
  logic [31:0] pc_in = '0;
  logic busy, pc_we, busy_v, pc_we_v;
  logic [31:0] pc_next, epc, cause, pc_next_v, epc_v, cause_v;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_vector_unit u_dut (
    .clk(clk), .rst_n(rst_n), .decode_en(decode_en), .opcode(opcode),
    .rtype_wr(rtype_wr), .alu_ovf(alu_ovf), .pc_in(pc_in),
    .exc_busy(busy), .pc_we(pc_we), .pc_next(pc_next), .epc(epc), .cause(cause)
  );

  exc_vector_unit #(.VECTORED(1'b1)) u_dut_v (
    .clk(clk), .rst_n(rst_n), .decode_en(decode_en), .opcode(opcode),
    .rtype_wr(rtype_wr), .alu_ovf(alu_ovf), .pc_in(pc_in),
    .exc_busy(busy_v), .pc_we(pc_we_v), .pc_next(pc_next_v), .epc(epc_v), .cause(cause_v)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit accepted(input logic [5:0] op);
    return op == 6'd35 || op == 6'd43 || op == 6'd0 ||
           op == 6'd11 || op == 6'd4  || op == 6'd2;
  endfunction

  task automatic idle_inputs();
    decode_en = 1'b0; rtype_wr = 1'b0; alu_ovf = 1'b0;
  endtask

  // kind: 0 illegal opcode, 1 overflow, 2 both at once
  task automatic run_fault(input int kind, input logic [5:0] op, input logic [31:0] pc);
    logic [31:0] c_exp, ret;
    c_exp = (kind == 1) ? 32'd1 : 32'd0;
    @(negedge clk);
    pc_in = pc;
    if (kind != 1) begin decode_en = 1'b1; opcode = op; end
    if (kind != 0) begin rtype_wr = 1'b1; alu_ovf = 1'b1; end
    @(negedge clk);
    check(busy === 1'b1, "R10 busy after entry", {31'b0, busy}, 32'd1);
    check(pc_we === 1'b0, "R6 no load in entry cycle", {31'b0, pc_we}, 32'd0);
    // junk triggers while busy must be ignored (R8)
    decode_en = 1'b1; opcode = 6'h3f; rtype_wr = 1'b1; alu_ovf = 1'b1;
    @(negedge clk);
    check(cause === c_exp, "R4 cause word", cause, c_exp);
    check(busy === 1'b1 && pc_we === 1'b0, "R10 busy in epc cycle", {30'b0, busy, pc_we}, 32'd2);
    @(negedge clk);
    ret = pc - 32'd4;
    check(epc === ret, "R5 saved address", epc, ret);
    check(pc_we === 1'b1, "R6 load strobe", {31'b0, pc_we}, 32'd1);
    check(pc_next === HBASE, "R6 single handler", pc_next, HBASE);
    ret = HBASE + (c_exp[0] ? HSTEP : 32'd0);
    check(pc_next_v === ret, "R7 vectored handler", pc_next_v, ret);
    idle_inputs();
    @(negedge clk);
    check(pc_we === 1'b0 && busy === 1'b0, "R6 back to idle", {30'b0, busy, pc_we}, 32'd0);
    check(cause === c_exp, "R8 cause not touched by junk", cause, c_exp);
  endtask

  initial begin
    for (int k = 0; k < 200000; k++) begin
      @(posedge clk);
      cyc = k;
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_e, hold_c;
    repeat (3) @(negedge clk);
    check(epc === 32'd0 && cause === 32'd0, "R1 regs reset", epc | cause, 32'd0);
    check(busy === 1'b0 && pc_we === 1'b0, "R1 strobes reset", {30'b0, busy, pc_we}, 32'd0);
    rst_n = 1'b1;

    // R3: overflow first so the later illegal cause is distinguishable
    run_fault(1, 6'd0, 32'h0000_1004);
    run_fault(0, 6'h3f, 32'h0000_2000);
    run_fault(1, 6'd0, 32'h0000_0000);   // wraps below zero (R5)
    run_fault(2, 6'h01, 32'h0000_0004);  // both at once: illegal wins (R3)

    // R3: either overflow signal alone does nothing
    @(negedge clk); rtype_wr = 1'b1; alu_ovf = 1'b0;
    @(negedge clk); check(busy === 1'b0, "R3 write without overflow", {31'b0, busy}, 32'd0);
    rtype_wr = 1'b0; alu_ovf = 1'b1;
    @(negedge clk); check(busy === 1'b0, "R3 overflow outside write state", {31'b0, busy}, 32'd0);
    idle_inputs();

    // R2: sweep every opcode at decode
    for (int op = 0; op < 64; op++) begin
      if (accepted(6'(op))) begin
        @(negedge clk); decode_en = 1'b1; opcode = 6'(op);
        @(negedge clk);
        check(busy === 1'b0, "R2 accepted opcode ignored", {31'b0, busy}, 32'd0);
        idle_inputs();
      end else begin
        if (op % 8 == 0) run_fault(1, 6'd0, 32'h1000_0000 + 32'(op * 4));
        run_fault(0, 6'(op), 32'h8000_0000 + 32'(op * 8));
      end
    end

    // R9: registers hold while pc_in wanders
    hold_e = epc; hold_c = cause;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); pc_in = 32'hdead_0000 + 32'(i);
    end
    @(negedge clk);
    check(epc === hold_e, "R9 epc held", epc, hold_e);
    check(cause === hold_c, "R9 cause held", cause, hold_c);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule